// File: doc/BRIEF.md
# MDIO Management Frame Sequencer

This block turns one management request into a complete serial transaction toward an Ethernet PHY. It drives a management clock, a data output and a separate output-enable for an external tri-state pad. The request holds a read/write select, a 5-bit PHY address, a 5-bit register number and, for writes, a 16-bit value. Each frame begins with a long run of driven ones, then carries a start code, an opcode, the two address fields, a turnaround, sixteen data bits and one trailing released clock. After that the pad goes back to a quiet idle state.

Each bit period has two halves. The low half carries any change on the data and enable outputs. In the high half the PHY's data line is read on a read frame. Both halves last a whole number of system clock cycles, set by a parameter, so the management clock can run far below the system clock. A read frame takes 64 management clocks and a write frame takes 65: a read releases the line for a single turnaround slot, while a write releases it for two. When a frame ends, a one-cycle done pulse is given and the captured read value is presented.

Top module: `mdio_frame_seq`

## Requirements
- R1: Every frame opens with 32 management clocks in which the output-enable is 1 and the data output is 1.
- R2: The four slots after the opening run are driven as 0,1 (start code) and then 1,0 for a read or 0,1 for a write (opcode), with the read/write select input 1 meaning read.
- R3: The next ten slots are driven with the PHY address and then the register number, each sent most significant bit first.
- R4: A read frame continues with one released slot (output-enable 0), then 16 released slots whose sampled input forms the read value, most significant bit first, then one released slot: 64 management clocks in all.
- R5: A write frame continues with two released slots, then the 16 write-data bits driven most significant bit first, then one released slot: 65 management clocks in all.
- R6: The data output and output-enable change only while the management clock is low, and the input is sampled at the end of the high half.
- R7: Each half of a management clock lasts HALF_DIV system cycles, so that done is seen 2*HALF_DIV*N+1 falling system edges after the start request is driven, where N is the frame's clock count.
- R8: After reset and after every frame, the management clock, data output and output-enable are all 0.
- R9: A start request that comes while a frame is in progress is ignored, and the running frame keeps its latched fields and its length.
- R10: Done is high for exactly one cycle per frame. The read-data output changes only when a read frame ends, and a write frame leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request pulse, accepted only while idle |
| rd_not_wr | input | 1 | 1 selects a read frame, 0 a write frame |
| phy_addr | input | 5 | Target PHY address |
| reg_addr | input | 5 | Target register number |
| wr_data | input | 16 | Value sent by a write frame |
| mdio_i | input | 1 | Data line as seen from the pad |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data driven to the pad |
| mdio_oe | output | 1 | Pad driver enable |
| rd_data | output | 16 | Last value captured by a read frame |
| done | output | 1 | One-cycle pulse at the end of a frame |

## Verification
Any fault in the slot counter or in the field decode shows up on the data or enable output at the first wrong management clock, within one bit period. The scoreboard compares every slot as it happens, so a shifted field or a turnaround of the wrong length is caught on the spot. A fault in the divider or in the end-of-frame test changes the number of clocks and the done timing, and it shows up by the end of that frame at the latest. A capture fault (wrong sampling half, wrong slots or wrong bit order) only shows in the read value presented with done.

// File: rtl/mdio_seq_pkg.sv
// Package: slot layout and shared types for the management frame sequencer.
// Assumes a fixed 32-slot opening run. Every later slot position is derived from it.
package mdio_seq_pkg;
    localparam int PRE_LEN       = 32;
    localparam int SLOT_ST0      = PRE_LEN;            // start code
    localparam int SLOT_OP0      = PRE_LEN + 2;        // opcode
    localparam int SLOT_HDR0     = PRE_LEN + 4;        // phy address then register
    localparam int SLOT_HDR_LAST = SLOT_HDR0 + 9;
    localparam int SLOT_TA0      = SLOT_HDR_LAST + 1;  // first released slot
    localparam int RD_CAP0       = SLOT_TA0 + 1;
    localparam int RD_CAP_LAST   = RD_CAP0 + 15;
    localparam int RD_LAST       = RD_CAP_LAST + 1;    // 63 -> 64 clocks
    localparam int WR_DAT0       = SLOT_TA0 + 2;
    localparam int WR_DAT_LAST   = WR_DAT0 + 15;
    localparam int WR_LAST       = WR_DAT_LAST + 1;    // 64 -> 65 clocks
    localparam int SLOT_W        = 7;

    typedef enum logic {
        OP_WRITE = 1'b0,
        OP_READ  = 1'b1
    } mdio_op_e;
endpackage

// File: rtl/mdio_half_timer.sv
// Half-period timer: while run is high, counts system cycles and pulses
// half_end on the last cycle of each HALF_DIV-cycle half period.
// Assumes HALF_DIV >= 1. The counter is held at zero while run is low.
module mdio_half_timer #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic half_end
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt;

    assign half_end = run && (cnt == CNT_LAST);

    // Counts cycles inside the current half period and wraps at its end.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (cnt == CNT_LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (int'(cnt) < HALF_DIV));
    a_r7_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(run) |-> (cnt == '0));
endmodule

// File: rtl/mdio_slot_map.sv
// Slot decoder: maps the slot index and the latched request to the pad value,
// the pad enable and a flag for read-capture slots. Purely combinational.
// Assumes slot never exceeds the last slot of the current frame type.
module mdio_slot_map
    import mdio_seq_pkg::*;
(
    input  logic [SLOT_W-1:0] slot,
    input  mdio_op_e          op,
    input  logic [4:0]        phy_addr,
    input  logic [4:0]        reg_addr,
    input  logic [15:0]       wr_data,
    output logic              bit_o,
    output logic              bit_oe,
    output logic              cap
);
    logic [9:0] hdr;
    logic [3:0] hdr_idx;
    logic [3:0] dat_idx;
    int         s;

    assign hdr     = {phy_addr, reg_addr};
    assign s       = int'(slot);
    assign hdr_idx = 4'(SLOT_HDR_LAST - s);
    assign dat_idx = 4'(WR_DAT_LAST - s);

    // Chooses the drive value and enable of the current slot.
    always_comb begin
        bit_o  = 1'b0;
        bit_oe = 1'b0;
        cap    = 1'b0;
        if (s < SLOT_ST0) begin
            bit_oe = 1'b1;
            bit_o  = 1'b1;
        end else if (s == SLOT_ST0) begin
            bit_oe = 1'b1;
        end else if (s == SLOT_ST0 + 1) begin
            bit_oe = 1'b1;
            bit_o  = 1'b1;
        end else if (s == SLOT_OP0) begin
            bit_oe = 1'b1;
            bit_o  = (op == OP_READ);
        end else if (s == SLOT_OP0 + 1) begin
            bit_oe = 1'b1;
            bit_o  = (op == OP_WRITE);
        end else if (s <= SLOT_HDR_LAST) begin
            bit_oe = 1'b1;
            bit_o  = hdr[hdr_idx];
        end else if (op == OP_READ) begin
            cap = (s >= RD_CAP0) && (s <= RD_CAP_LAST);
        end else if ((s >= WR_DAT0) && (s <= WR_DAT_LAST)) begin
            bit_oe = 1'b1;
            bit_o  = wr_data[dat_idx];
        end
    end
endmodule

// File: rtl/mdio_rd_shift.sv
// Read-capture shifter: shifts the pad input in, MSB first, on each shift_en.
// Assumes the controller asserts shift_en exactly 16 times per read frame.
module mdio_rd_shift #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          shift_en,
    input  logic          din,
    output logic [DW-1:0] q
);
    // Shifts one sampled bit into the low end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (shift_en) begin
            q <= {q[DW-2:0], din};
        end
    end
endmodule

// File: rtl/mdio_frame_seq.sv
// Management frame sequencer top: accepts a request while idle, walks the
// slot counter through two halves per slot, and finishes with a done pulse.
// Assumes start is ignored while a frame is in progress and mdio_i is
// synchronous to clk.
module mdio_frame_seq
    import mdio_seq_pkg::*;
#(
    parameter int HALF_DIV = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        rd_not_wr,
    input  logic [4:0]  phy_addr,
    input  logic [4:0]  reg_addr,
    input  logic [15:0] wr_data,
    input  logic        mdio_i,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    output logic [15:0] rd_data,
    output logic        done
);
    localparam logic [SLOT_W-1:0] LAST_RD = SLOT_W'(RD_LAST);
    localparam logic [SLOT_W-1:0] LAST_WR = SLOT_W'(WR_LAST);

    logic              busy;
    logic [SLOT_W-1:0] slot;
    mdio_op_e          op_q;
    logic [4:0]        pa_q;
    logic [4:0]        ra_q;
    logic [15:0]       wd_q;
    logic              half_end;
    logic              map_o;
    logic              map_oe;
    logic              map_cap;
    logic              shift_en;
    logic [15:0]       shift_q;
    logic [SLOT_W-1:0] last_slot;

    assign last_slot = (op_q == OP_READ) ? LAST_RD : LAST_WR;
    assign shift_en  = half_end && mdc && map_cap;
    assign mdio_o    = busy && map_o;
    assign mdio_oe   = busy && map_oe;

    mdio_half_timer #(.HALF_DIV(HALF_DIV)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy),
        .half_end (half_end)
    );

    mdio_slot_map u_map (
        .slot     (slot),
        .op       (op_q),
        .phy_addr (pa_q),
        .reg_addr (ra_q),
        .wr_data  (wd_q),
        .bit_o    (map_o),
        .bit_oe   (map_oe),
        .cap      (map_cap)
    );

    mdio_rd_shift #(.DW(16)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .din      (mdio_i),
        .q        (shift_q)
    );

    // Frame control: accept, half toggling, slot advance and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            slot    <= '0;
            mdc     <= 1'b0;
            done    <= 1'b0;
            rd_data <= '0;
            op_q    <= OP_WRITE;
            pa_q    <= '0;
            ra_q    <= '0;
            wd_q    <= '0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy <= 1'b1;
                    slot <= '0;
                    mdc  <= 1'b0;
                    op_q <= rd_not_wr ? OP_READ : OP_WRITE;
                    pa_q <= phy_addr;
                    ra_q <= reg_addr;
                    wd_q <= wr_data;
                end
            end else if (half_end) begin
                if (!mdc) begin
                    mdc <= 1'b1;
                end else begin
                    mdc <= 1'b0;
                    if (slot == last_slot) begin
                        busy <= 1'b0;
                        slot <= '0;
                        done <= 1'b1;
                        if (op_q == OP_READ) begin
                            rd_data <= shift_q;
                        end
                    end else begin
                        slot <= slot + 1'b1;
                    end
                end
            end
        end
    end

    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_o && !mdio_oe));
    a_r6_o_low_half: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mdio_o) |-> !mdc);
    a_r6_oe_low_half: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mdio_oe) |-> !mdc);
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r10_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_data) |-> done);
    a_r4_slot_bound: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (slot <= last_slot));
    a_r9_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy) && busy |-> ($stable(pa_q) && $stable(ra_q) && $stable(wd_q)));
endmodule

// File: tb/mdio_frame_seq_bench.sv
// Scoreboard bench: a driver task queues the expected {oe,o} of every slot,
// a monitor pops one entry at each management clock rise and compares.
module mdio_frame_seq_bench;
    localparam int HD = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        rd_not_wr = 1'b0;
    logic [4:0]  phy_addr = '0;
    logic [4:0]  reg_addr = '0;
    logic [15:0] wr_data = '0;
    logic        mdio_i = 1'b1;
    logic        mdc;
    logic        mdio_o;
    logic        mdio_oe;
    logic [15:0] rd_data;
    logic        done;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [1:0] exp_q[$];
    bit         cur_rd;
    logic [15:0] phy_rsp;
    int         rise_idx;
    logic       prev_mdc = 1'b0;
    logic [1:0] prev_pad = 2'b00;

    always #4 clk = ~clk;

    mdio_frame_seq #(.HALF_DIV(HD)) u_mdio_frame_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .rd_not_wr(rd_not_wr),
        .phy_addr(phy_addr), .reg_addr(reg_addr), .wr_data(wr_data),
        .mdio_i(mdio_i), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
        .rd_data(rd_data), .done(done)
    );

    function automatic string req_of(int idx, bit rd);
        if (idx < 32) return "R1";
        if (idx < 36) return "R2";
        if (idx < 46) return "R3";
        return rd ? "R4" : "R5";
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Monitor: slot compare at each rise, PHY model, high-half stability.
    always @(negedge clk) begin
        if (rst_n) begin
            if (mdc && !prev_mdc) begin
                if (exp_q.size() == 0) begin
                    check(0, "R8", "unexpected clock rise", 1, 0);
                end else begin
                    logic [1:0] e;
                    e = exp_q.pop_front();
                    check({mdio_oe, mdio_o} == e, req_of(rise_idx, cur_rd),
                          $sformatf("slot %0d {oe,o}", rise_idx), {mdio_oe, mdio_o}, e);
                end
                if (cur_rd && rise_idx >= 47 && rise_idx <= 62)
                    mdio_i = phy_rsp[15 - (rise_idx - 47)];
                else
                    mdio_i = 1'b1;
                rise_idx++;
            end else if (mdc && prev_mdc) begin
                check({mdio_oe, mdio_o} == prev_pad, "R6", "pad change in high half",
                      {mdio_oe, mdio_o}, prev_pad);
            end
        end
        prev_mdc = mdc;
        prev_pad = {mdio_oe, mdio_o};
    end

    // Driver: queue expectation, issue request, time it, check the end state.
    task automatic run_frame(bit rd, logic [4:0] pa, logic [4:0] ra,
                             logic [15:0] wd, logic [15:0] rsp, bit poke);
        int n;
        int cyc;
        logic [15:0] rd_before;
        logic [9:0] hdr;
        n = rd ? 64 : 65;
        hdr = {pa, ra};
        for (int i = 0; i < 32; i++) exp_q.push_back(2'b11);
        exp_q.push_back(2'b10);
        exp_q.push_back(2'b11);
        exp_q.push_back(rd ? 2'b11 : 2'b10);
        exp_q.push_back(rd ? 2'b10 : 2'b11);
        for (int i = 9; i >= 0; i--) exp_q.push_back({1'b1, hdr[i]});
        if (rd) begin
            for (int i = 0; i < 18; i++) exp_q.push_back(2'b00);
        end else begin
            exp_q.push_back(2'b00);
            exp_q.push_back(2'b00);
            for (int i = 15; i >= 0; i--) exp_q.push_back({1'b1, wd[i]});
            exp_q.push_back(2'b00);
        end
        cur_rd = rd;
        phy_rsp = rsp;
        rise_idx = 0;
        rd_before = rd_data;
        rd_not_wr = rd; phy_addr = pa; reg_addr = ra; wr_data = wd;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        while (!done && cyc < 1000) begin
            @(negedge clk);
            cyc++;
            if (poke && cyc == 100) begin
                // R9: a second request with other fields while busy
                start = 1'b1; rd_not_wr = !rd; phy_addr = ~pa;
                reg_addr = ~ra; wr_data = ~wd;
            end else begin
                start = 1'b0;
            end
        end
        check(cyc == 2 * HD * n + 1, "R7", "cycles to done", cyc, 2 * HD * n + 1);
        check(rise_idx == n, rd ? "R4" : "R5", "clock count", rise_idx, n);
        check(exp_q.size() == 0, "R9", "slots left unconsumed", exp_q.size(), 0);
        exp_q.delete();
        if (rd)
            check(rd_data == rsp, "R4", "read value", rd_data, rsp);
        else
            check(rd_data == rd_before, "R10", "rd_data after write", rd_data, rd_before);
        @(negedge clk);
        check(done == 1'b0, "R10", "done width", done, 0);
        check({mdc, mdio_o, mdio_oe} == 3'b000, "R8", "idle pad", {mdc, mdio_o, mdio_oe}, 0);
        check(rd_data == (rd ? rsp : rd_before), "R10", "rd_data held",
              rd_data, rd ? rsp : rd_before);
        repeat (5) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check({mdc, mdio_o, mdio_oe, done} == 4'b0000, "R8", "reset outputs",
              {mdc, mdio_o, mdio_oe, done}, 0);
        check(rd_data == 16'h0, "R10", "reset rd_data", rd_data, 0);
        rst_n = 1'b1;
        @(negedge clk);
        run_frame(1'b1, 5'h13, 5'h02, 16'h0000, 16'hA5C3, 1'b0);
        run_frame(1'b0, 5'h0C, 5'h19, 16'h8001, 16'h0000, 1'b0);
        run_frame(1'b0, 5'h1F, 5'h00, 16'h5A3C, 16'h0000, 1'b1);
        run_frame(1'b1, 5'h00, 5'h1F, 16'h0000, 16'h0001, 1'b1);
        run_frame(1'b1, 5'h15, 5'h0A, 16'h0000, 16'hFFFE, 1'b0);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule